// File: doc/BRIEF.md
# Clock Generator Configuration Serial Slave

This block is the two-wire configuration port of a system clock generator. It answers on a fixed 7-bit bus address and holds seven 8-bit control registers that set output enables, spread mode and the frequency code. There is no register pointer. A write always lands at register 0: the first two bytes after the address are acknowledged and thrown away, and every byte after that fills the next register in rising order until the master ends the transfer. A read always returns a length byte first, then the registers from register 0 upward.

SCL and SDA are sampled on the system clock through synchronizers. Start and stop conditions are found as an SDA edge while SCL is high. The slave only pulls SDA low, through an open-drain enable. A 5-bit strap value is captured while the power-on reset is held. While bit 3 of register 0 is clear, that strap value is the frequency code; once the bit is set, the code comes from register 0 instead. The inverted strap value can be read back in the top five bits of register 4.

Top module: `clkCfgSlave`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (write) and 0xD3 (read), which is 7-bit address 0x69 followed by the R/W bit.
- R2: On a write, the two bytes that follow the address are acknowledged but change no register.
- R3: On a write, the third and later bytes load registers 0, 1, 2 and so on in ascending order. A stop after any complete byte leaves every register that was not reached at its old value.
- R4: Every byte the slave receives in a transfer addressed to it is acknowledged (SDA driven low in the ninth clock), including bytes sent past register 6. Such extra bytes change no register.
- R5: A read returns the byte count 7 first, then registers 0 to 6, then 0xFF for every further byte, for as long as the master acknowledges.
- R6: After reset, register 0 reads 0x00 and registers 1 to 6 read 0xFF.
- R7: The 5-bit frequency code equals the latched strap value while register 0 bit 3 is 0. While that bit is 1, the code is {register 0 bit 2, register 0 bits 7:4}, with bit 2 as the MSB.
- R8: The strap inputs are captured on every clock while reset is held. A change on them after reset is released has no effect.
- R9: Register 4 bits 7:3 read back as the bitwise inverse of the latched strap value. A write to register 4 changes only bits 2:0, and the stored bits 7:3 keep their reset value 11111.
- R10: A repeated start ends the current transfer and begins a new one at the address byte, with the register sequence restarting at register 0.
- R11: An address byte other than 0xD2 or 0xD3 is not acknowledged. The slave leaves SDA released, and the bytes that follow, up to the next stop, change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low power-on reset; strap capture while low |
| sclIn | input | 1 | Serial clock from the bus |
| sdaIn | input | 1 | Serial data level on the bus |
| sdaOe | output | 1 | When 1, the slave pulls SDA low |
| strapIn | input | 5 | Hardware frequency strap levels |
| cfgRegs | output | 56 | Registers 0 to 6; register n at bits 8n+7:8n |
| freqSel | output | 5 | Selected frequency code |

## Verification
The assertions check, on every cycle, that the slave changes SDA only while SCL is low and that registers move only on a write strobe from the control. They also check that the datapath strobes are mutually exclusive, that a start always returns the control to address reception, that a foreign address sends it idle, and that the strap latch holds after reset. The bench scenarios are needed for everything that depends on byte order over a whole transfer. That covers the discard of the two leading write bytes, register order and partial writes, the byte count and the 0xFF padding on reads, the inverted strap read-back, the frequency-code selection, and the restart at register 0 after a repeated start.

// File: rtl/clkCfgPkg.sv
package clkCfgPkg;

  localparam int STRAP_W = 5;

  typedef struct packed {
    logic shiftIn;
    logic writeByte;
    logic loadCount;
    logic loadNext;
    logic shiftTx;
    logic idxClr;
  } cfgStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } busState_t;

endpackage

// File: rtl/i2cCtrl.sv
module i2cCtrl
  import clkCfgPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output logic       sdaBit,
  output logic       sdaOe,
  output cfgStrobe_t strb
);

  localparam logic [3:0] BITS_PER_BYTE = 4'd8;
  localparam logic [1:0] SKIP_BYTES = 2'd2;

  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclS, sdaS, sclP, sdaP;
  logic sclRise, sclFall, startC, stopC, byteEnd;

  busState_t  state;
  logic [3:0] bitCnt;
  logic [1:0] skipCnt;
  logic       isRead;
  logic       mAck;

  // input synchronizers, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh <= '1;
      sdaSh <= '1;
      sclP  <= 1'b1;
      sdaP  <= 1'b1;
    end else begin
      sclSh <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclP  <= sclS;
      sdaP  <= sdaS;
    end
  end

  assign sclS    = sclSh[SYNC_STAGES-1];
  assign sdaS    = sdaSh[SYNC_STAGES-1];
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;
  assign startC  = sclS & sclP & sdaP & ~sdaS;
  assign stopC   = sclS & sclP & ~sdaP & sdaS;
  assign byteEnd = (bitCnt == BITS_PER_BYTE);
  assign sdaBit  = sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      skipCnt <= '0;
      isRead  <= 1'b0;
      mAck    <= 1'b0;
    end else if (startC) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopC) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          else if (sclFall && byteEnd) begin
            if (rxByte[7:1] == DEV_ADDR) begin
              state  <= ST_ADDR_ACK;
              isRead <= rxByte[0];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            bitCnt  <= '0;
            skipCnt <= '0;
            state   <= isRead ? ST_RD_BYTE : ST_WR_BYTE;
          end
        end
        ST_WR_BYTE: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          else if (sclFall && byteEnd) begin
            state <= ST_WR_ACK;
            if (skipCnt != SKIP_BYTES) skipCnt <= skipCnt + 2'd1;
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            state  <= ST_WR_BYTE;
            bitCnt <= '0;
          end
        end
        ST_RD_BYTE: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          else if (sclFall && byteEnd) state <= ST_RD_ACK;
        end
        ST_RD_ACK: begin
          if (sclRise) mAck <= ~sdaS;
          else if (sclFall) begin
            if (mAck) begin
              state  <= ST_RD_BYTE;
              bitCnt <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // strobes towards the datapath
  always_comb begin
    strb = '0;
    strb.idxClr = startC;
    if (!startC && !stopC) begin
      strb.shiftIn   = sclRise && (state == ST_ADDR || state == ST_WR_BYTE);
      strb.writeByte = sclFall && byteEnd && (state == ST_WR_BYTE) && (skipCnt == SKIP_BYTES);
      strb.loadCount = sclFall && (state == ST_ADDR_ACK) && isRead;
      strb.loadNext  = sclFall && (state == ST_RD_ACK) && mAck;
      strb.shiftTx   = sclFall && !byteEnd && (state == ST_RD_BYTE);
    end
  end

  assign sdaOe = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                 ((state == ST_RD_BYTE) && !txBit);

  // R4: the slave moves SDA only while SCL is low
  p_oe_scl_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS);

  // R10: any start returns the control to address reception
  p_start_addr_r10: assert property (@(posedge clk) disable iff (!rstN)
    startC |=> (state == ST_ADDR));

  // R11: a foreign address sends the control idle
  p_foreign_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && sclFall && byteEnd && !startC && !stopC &&
     rxByte[7:1] != DEV_ADDR) |=> (state == ST_IDLE));

endmodule

// File: rtl/cfgDatapath.sv
module cfgDatapath
  import clkCfgPkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter int STRAP_BYTE = 4,
  parameter logic [8*NUM_REGS-1:0] REG_DEFAULTS = {{(NUM_REGS-1){8'hFF}}, 8'h00}
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cfgStrobe_t              strb,
  input  logic                    sdaBit,
  input  logic [STRAP_W-1:0]      strapIn,
  output logic [7:0]              rxByte,
  output logic                    txBit,
  output logic [8*NUM_REGS-1:0]   cfgRegs,
  output logic [STRAP_W-1:0]      freqSel
);

  localparam int IDX_W = $clog2(NUM_REGS + 1);
  localparam int RW_W  = 8 - STRAP_W;
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NUM_REGS);

  logic [8*NUM_REGS-1:0] regFlat;
  logic [IDX_W-1:0]      idx;
  logic [7:0]            rxShift, txShift, rdVal;
  logic [STRAP_W-1:0]    strapLatch;
  logic [7:0]            byte0;

  // strap capture while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) strapLatch <= strapIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (strb.shiftIn) rxShift <= {rxShift[6:0], sdaBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
    end else if (strb.idxClr || strb.loadCount) begin
      idx <= '0;
    end else if ((strb.writeByte || strb.loadNext) && idx < IDX_END) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regFlat <= REG_DEFAULTS;
    end else if (strb.writeByte) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (idx == IDX_W'(i)) begin
          if (i == STRAP_BYTE) regFlat[8*i +: RW_W] <= rxShift[RW_W-1:0];
          else                 regFlat[8*i +: 8]    <= rxShift;
        end
      end
    end
  end

  always_comb begin
    rdVal = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) begin
        if (i == STRAP_BYTE) rdVal = {~strapLatch, regFlat[8*i +: RW_W]};
        else                 rdVal = regFlat[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               txShift <= 8'hFF;
    else if (strb.loadCount) txShift <= 8'(NUM_REGS);
    else if (strb.loadNext)  txShift <= rdVal;
    else if (strb.shiftTx)   txShift <= {txShift[6:0], 1'b1};
  end

  assign byte0   = regFlat[7:0];
  assign freqSel = byte0[3] ? {byte0[2], byte0[7:4]} : strapLatch;
  assign rxByte  = rxShift;
  assign txBit   = txShift[7];
  assign cfgRegs = regFlat;

  // R3: registers change only on a write strobe
  p_regs_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.writeByte |=> $stable(cfgRegs));

  // R5: datapath strobes never overlap
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.writeByte, strb.loadCount, strb.loadNext, strb.shiftTx}));

  // R8: strap latch holds once reset is released
  p_strap_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(strapLatch));

endmodule

// File: rtl/clkCfgSlave.sv
module clkCfgSlave
  import clkCfgPkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter int STRAP_BYTE = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [8*NUM_REGS-1:0] REG_DEFAULTS = {{(NUM_REGS-1){8'hFF}}, 8'h00}
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  input  logic [STRAP_W-1:0]    strapIn,
  output logic [8*NUM_REGS-1:0] cfgRegs,
  output logic [STRAP_W-1:0]    freqSel
);

  cfgStrobe_t strb;
  logic [7:0] rxByte;
  logic       txBit;
  logic       sdaBit;

  i2cCtrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEV_ADDR(DEV_ADDR)
  ) i_ctrl (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .rxByte(rxByte),
    .txBit(txBit),
    .sdaBit(sdaBit),
    .sdaOe(sdaOe),
    .strb(strb)
  );

  cfgDatapath #(
    .NUM_REGS(NUM_REGS),
    .STRAP_BYTE(STRAP_BYTE),
    .REG_DEFAULTS(REG_DEFAULTS)
  ) i_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .sdaBit(sdaBit),
    .strapIn(strapIn),
    .rxByte(rxByte),
    .txBit(txBit),
    .cfgRegs(cfgRegs),
    .freqSel(freqSel)
  );

endmodule

// File: tb/test_clkCfgSlave.sv
module test_clkCfgSlave;

  localparam int Q = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic        scl = 1'b1;
  logic        msda = 1'b1;
  logic        sdaOe;
  logic [4:0]  strapIn;
  logic [55:0] cfgRegs;
  logic [4:0]  freqSel;
  wire         sdaLine = msda & ~sdaOe;

  clkCfgSlave i_clkCfgSlave (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strapIn(strapIn), .cfgRegs(cfgRegs), .freqSel(freqSel)
  );

  int nChk = 0, nFail = 0;
  bit done = 0;
  logic [7:0] expRegs [7];
  logic [4:0] strapVal;
  logic [7:0] wbuf [12];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    msda = 1'b1; q(); scl = 1'b1; q(); msda = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic busStop();
    msda = 1'b0; q(); scl = 1'b1; q(); msda = 1'b1; q();
  endtask

  task automatic wbit(input logic b);
    msda = b; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
  endtask

  task automatic rbit(output logic b);
    msda = 1'b1; q(); scl = 1'b1; q(); b = sdaLine; q(); scl = 1'b0; q();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(ack);
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      rbit(b);
      d[i] = b;
    end
    wbit(nack);
  endtask

  function automatic logic [7:0] expRead(input int n);
    if (n == 0) return 8'd7;
    if (n - 1 == 4) return {~strapVal, expRegs[4][2:0]};
    if (n - 1 < 7) return expRegs[n-1];
    return 8'hFF;
  endfunction

  function automatic logic [4:0] expFreq();
    return expRegs[0][3] ? {expRegs[0][2], expRegs[0][7:4]} : strapVal;
  endfunction

  function automatic void modelWrite(input int k, input logic [7:0] d);
    if (k == 4) expRegs[4] = {expRegs[4][7:3], d[2:0]};
    else if (k < 7) expRegs[k] = d;
  endfunction

  task automatic checkRegs(input string tag);
    logic [55:0] e;
    for (int k = 0; k < 7; k++) e[8*k +: 8] = expRegs[k];
    chk(tag, cfgRegs, e);
    chk("R7 freqSel", freqSel, expFreq());
  endtask

  // n data bytes from wbuf after the two discarded bytes
  task automatic doWrite(input int n, input string tag);
    logic a;
    busStart();
    wbyte(8'hD2, a); chk("R1 write address ack", a, 0);
    wbyte(8'($urandom), a); chk("R2 command byte ack", a, 0);
    wbyte(8'($urandom), a); chk("R2 count byte ack", a, 0);
    for (int k = 0; k < n; k++) begin
      wbyte(wbuf[k], a);
      chk("R4 data byte ack", a, 0);
      modelWrite(k, wbuf[k]);
    end
    busStop(); q();
    checkRegs(tag);
  endtask

  task automatic doRead(input int n);
    logic a;
    logic [7:0] d;
    busStart();
    wbyte(8'hD3, a); chk("R1 read address ack", a, 0);
    for (int i = 0; i < n; i++) begin
      rbyte(i == n - 1, d);
      chk(i == 5 ? "R9 strap readback" : "R5 read stream", d, expRead(i));
    end
    busStop(); q();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL R3 watchdog actual hung expected done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    logic a;
    void'($urandom(32'd2024));
    rstN = 1'b0;
    strapVal = 5'b10110;
    strapIn = strapVal;
    expRegs[0] = 8'h00;
    for (int k = 1; k < 7; k++) expRegs[k] = 8'hFF;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    strapIn = 5'b01001;               // R8: ignored after reset
    q();
    checkRegs("R6 reset defaults");
    chk("R8 strap held", freqSel, strapVal);
    chk("R4 sda released at idle", sdaOe, 0);

    // read all at defaults plus two padding bytes
    doRead(10);

    // R2: only command and count bytes
    doWrite(0, "R2 no change");

    // full write of 7 bytes, random data
    for (int k = 0; k < 7; k++) wbuf[k] = 8'($urandom);
    doWrite(7, "R3 full write");
    doRead(8);

    // partial write of 3 bytes
    for (int k = 0; k < 3; k++) wbuf[k] = 8'($urandom);
    doWrite(3, "R3 partial write");

    // R4: bytes past register 6 acked and dropped
    for (int k = 0; k < 10; k++) wbuf[k] = 8'($urandom);
    doWrite(10, "R4 overflow write");

    // R9: register 4 top bits read-only
    for (int k = 0; k < 5; k++) wbuf[k] = 8'h00;
    doWrite(5, "R9 reg4 zeros");
    chk("R9 stored bits", cfgRegs[39:35], 5'b11111);
    doRead(6);

    // R11: foreign addresses
    begin
      logic [7:0] bad [2] = '{8'hAA, 8'hD0};
      for (int j = 0; j < 2; j++) begin
        busStart();
        wbyte(bad[j], a); chk("R11 foreign address nack", a, 1);
        for (int k = 0; k < 4; k++) begin
          wbyte(8'h5A, a); chk("R11 no ack after foreign", a, 1);
        end
        busStop(); q();
        checkRegs("R11 regs unchanged");
      end
    end

    // R7: register-selected frequency code, random
    for (int j = 0; j < 6; j++) begin
      wbuf[0] = 8'($urandom) | 8'h08;
      if (j == 5) wbuf[0] = 8'h00;
      doWrite(1, "R7 byte0 write");
    end

    // R10: repeated start from write into read
    busStart();
    wbyte(8'hD2, a); chk("R10 address ack", a, 0);
    wbyte(8'h11, a); wbyte(8'h22, a);
    wbyte(8'h3C, a); chk("R10 data ack", a, 0);
    modelWrite(0, 8'h3C);
    busStart();
    wbyte(8'hD3, a); chk("R10 read after restart ack", a, 0);
    begin
      logic [7:0] d;
      rbyte(1'b0, d); chk("R10 count first", d, 8'd7);
      rbyte(1'b1, d); chk("R10 restart at register 0", d, 8'h3C);
    end
    busStop(); q();
    checkRegs("R10 regs");

    // random partial writes followed by reads
    for (int j = 0; j < 8; j++) begin
      int n;
      n = int'($urandom % 10);
      for (int k = 0; k < 10; k++) wbuf[k] = 8'($urandom);
      doWrite(n, "R3 random write");
      doRead(1 + int'($urandom % 9));
    end

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule